// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block derives the bit clock of a synchronous serial port from the single system clock. Two dividers are cascaded. The first is a prescaler whose ratio is an even number from 2 to 254. The second divides by one plus an 8-bit rate field, so its ratio runs from 1 to 256. The resulting bit period is `prescale * (1 + rate)` system clocks, and the bit clock has an exact 50 % duty cycle. Because the prescale value is even, each half period is a whole number of system clocks: `(prescale / 2) * (1 + rate)`.

The prescaler is held in an 8-bit register that has a write port and a read-back port. Bit 0 of this register always reads as zero. Software programs the register, drives the rate field and the idle level, and then raises the port enable. The shifter logic uses the bit clock level and two one-cycle strobes, one for the rising bit-clock edge and one for the falling edge. While the port is disabled, both counters are held at zero and the bit clock rests at its idle level. A new prescale, rate or idle-level value takes effect only at a period boundary, which is the toggle that returns the bit clock to its idle level. It never takes effect in the middle of a period.

Top module: `bitclk_gen`

## Requirements
- R1: While enabled, the bit clock toggles every `(P/2)*(1+S)` system clocks, where P is the prescale read-back value and S is the rate field. The full bit period is therefore `P*(1+S)` clocks. After enable rises, the first toggle comes `(P/2)*(1+S)` clock edges later.
- R2: Read-back bit 0 is always 0. A write of an odd value V reads back as V-1, and a write of an even value V reads back as V. The read-back changes on the clock edge that takes the write.
- R3: After reset the prescaler reads 2. A write whose value is 0 or 1 is ignored, and the previous value is kept.
- R4: The rate field spans 0 to 255, which gives a second-stage ratio of 1 to 256. With P=2 and S=255 the half period is 256 clocks.
- R5: `riseStrobe` is high for exactly the one cycle in which the bit clock is first seen high after a low-to-high toggle. `fallStrobe` does the same for a high-to-low toggle. The two strobes are never high together.
- R6: While `portEnable` is 0, the bit clock follows `idlePol` one cycle later, no strobe is produced, and both counters reload. If the port is disabled mid-period and enabled again, the next toggle comes a full half period after the new enable.
- R7: A prescale or rate change made mid-period is first used after the next toggle that returns the bit clock to its idle level.
- R8: With `idlePol`=1 the bit clock idles high and the first strobe after enable is a falling strobe. With `idlePol`=0 the first strobe is a rising strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psWrEn | input | 1 | Prescale register write strobe |
| psWrData | input | 8 | Prescale value to write |
| psRdData | output | 8 | Prescale read-back, bit 0 always zero |
| rateIn | input | 8 | Second-stage rate field S, ratio 1+S |
| idlePol | input | 1 | Idle level of the bit clock |
| portEnable | input | 1 | Runs the dividers when high |
| bitClk | output | 1 | Bit clock level |
| riseStrobe | output | 1 | One-cycle strobe on a rising bit-clock edge |
| fallStrobe | output | 1 | One-cycle strobe on a falling bit-clock edge |

## Verification
On every cycle the assertions check four things. The read-back has bit 0 clear and is at least 2. The strobes are exclusive and each one agrees with the bit-clock transition it marks. Every bit-clock change made while enabled carries a strobe, and a disabled port is idle with no strobes. The cycle-exact spacing of toggles for a given prescale and rate, the full 256 ratio, and the reload of the counters after a mid-period disable can only be shown by the bench's scenarios. The same holds for the deferral of a mid-period configuration change to the next idle-returning toggle. For these the scoreboard predicts the stamp of every strobe.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clear;   // port disabled: reload counters, idle output
    logic toggle;  // both stages wrapped: invert bit clock
  } bitclk_strobe_t;
endpackage

// File: rtl/bitclk_stage.sv
module bitclk_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         advance,
  input  logic [W-1:0] limit,
  output logic         wrap
);
  logic [W-1:0] count;

  assign wrap = advance && (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clear) begin
      count <= '0;
    end else if (advance) begin
      if (wrap) count <= '0;
      else      count <= count + 1'b1;
    end
  end
endmodule

// File: rtl/bitclk_ctrl.sv
module bitclk_ctrl
  import bitclk_pkg::*;
#(
  parameter int HALF_W = 7,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              portEnable,
  input  logic [HALF_W-1:0] halfLimit,
  input  logic [RATE_W-1:0] rateLimit,
  output bitclk_strobe_t    ctl
);
  localparam int NUM_STAGES = 2;

  logic [NUM_STAGES:0] stageAdv;
  logic                stopAll;

  assign stopAll     = !portEnable;
  assign stageAdv[0] = portEnable;

  generate
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_pre
        bitclk_stage #(.W(HALF_W)) u_stage (
          .clk(clk), .rst_n(rst_n), .clear(stopAll),
          .advance(stageAdv[g]), .limit(halfLimit), .wrap(stageAdv[g+1])
        );
      end else begin : g_rate
        bitclk_stage #(.W(RATE_W)) u_stage (
          .clk(clk), .rst_n(rst_n), .clear(stopAll),
          .advance(stageAdv[g]), .limit(rateLimit), .wrap(stageAdv[g+1])
        );
      end
    end
  endgenerate

  always_comb begin
    ctl        = '0;
    ctl.clear  = stopAll;
    ctl.toggle = stageAdv[NUM_STAGES];
  end
endmodule

// File: rtl/bitclk_datapath.sv
module bitclk_datapath
  import bitclk_pkg::*;
#(
  parameter int PS_W   = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psWrEn,
  input  logic [PS_W-1:0]   psWrData,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              idlePol,
  input  bitclk_strobe_t    ctl,
  output logic [PS_W-1:0]   psRdData,
  output logic [PS_W-2:0]   halfLimit,
  output logic [RATE_W-1:0] rateLimit,
  output logic              bitClk,
  output logic              riseStrobe,
  output logic              fallStrobe
);
  localparam int HALF_W = PS_W - 1;
  localparam logic [HALF_W-1:0] HALF_RESET = HALF_W'(1);

  logic [HALF_W-1:0] psHalfReg;   // programmed prescale / 2
  logic [HALF_W-1:0] halfAct;     // prescale / 2 in use
  logic [RATE_W-1:0] rateAct;
  logic              polAct;
  logic              clkQ;
  logic              riseQ;
  logic              fallQ;
  logic              boundary;
  logic              loadCfg;

  // Programmed register: bit 0 is not stored; zero half value is refused
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psHalfReg <= HALF_RESET;
    end else if (psWrEn && (psWrData[PS_W-1:1] != '0)) begin
      psHalfReg <= psWrData[PS_W-1:1];
    end
  end

  assign psRdData  = {psHalfReg, 1'b0};

  // Configuration is adopted when disabled or on the idle-returning toggle
  assign boundary = ctl.toggle && (clkQ != polAct);
  assign loadCfg  = ctl.clear || boundary;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halfAct <= HALF_RESET;
      rateAct <= '0;
      polAct  <= 1'b0;
    end else if (loadCfg) begin
      halfAct <= psHalfReg;
      rateAct <= rateIn;
      polAct  <= idlePol;
    end
  end

  assign halfLimit = halfAct - 1'b1;
  assign rateLimit = rateAct;

  // Bit clock level and edge strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkQ  <= 1'b0;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else if (ctl.clear) begin
      clkQ  <= idlePol;
      riseQ <= 1'b0;
      fallQ <= 1'b0;
    end else begin
      riseQ <= ctl.toggle && !clkQ;
      fallQ <= ctl.toggle && clkQ;
      if (ctl.toggle) clkQ <= !clkQ;
    end
  end

  assign bitClk     = clkQ;
  assign riseStrobe = riseQ;
  assign fallStrobe = fallQ;
endmodule

// File: rtl/bitclk_gen.sv
module bitclk_gen
  import bitclk_pkg::*;
#(
  parameter int PS_W   = 8,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psWrEn,
  input  logic [PS_W-1:0]   psWrData,
  output logic [PS_W-1:0]   psRdData,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              idlePol,
  input  logic              portEnable,
  output logic              bitClk,
  output logic              riseStrobe,
  output logic              fallStrobe
);
  localparam int HALF_W = PS_W - 1;

  bitclk_strobe_t    ctl;
  logic [HALF_W-1:0] halfLimit;
  logic [RATE_W-1:0] rateLimit;

  bitclk_ctrl #(.HALF_W(HALF_W), .RATE_W(RATE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .portEnable(portEnable),
    .halfLimit(halfLimit), .rateLimit(rateLimit), .ctl(ctl)
  );

  bitclk_datapath #(.PS_W(PS_W), .RATE_W(RATE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .psWrEn(psWrEn), .psWrData(psWrData),
    .rateIn(rateIn), .idlePol(idlePol), .ctl(ctl),
    .psRdData(psRdData), .halfLimit(halfLimit), .rateLimit(rateLimit),
    .bitClk(bitClk), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe)
  );
endmodule

// File: rtl/bitclk_gen_chk.sv
module bitclk_gen_chk #(
  parameter int PS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic [PS_W-1:0] psRdData,
  input logic            idlePol,
  input logic            portEnable,
  input logic            bitClk,
  input logic            riseStrobe,
  input logic            fallStrobe
);
  p_even_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    psRdData[0] == 1'b0);

  p_min_prescale_r3: assert property (@(posedge clk) disable iff (!rst_n)
    psRdData >= PS_W'(2));

  p_strobe_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(riseStrobe && fallStrobe));

  p_rise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    riseStrobe |-> (bitClk && !$past(bitClk)));

  p_fall_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fallStrobe |-> (!bitClk && $past(bitClk)));

  p_edge_strobed_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(portEnable) && (bitClk != $past(bitClk))) |-> (riseStrobe || fallStrobe));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !portEnable |=> ((bitClk == $past(idlePol)) && !riseStrobe && !fallStrobe));
endmodule

bind bitclk_gen bitclk_gen_chk #(.PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psRdData(psRdData), .idlePol(idlePol),
  .portEnable(portEnable), .bitClk(bitClk), .riseStrobe(riseStrobe),
  .fallStrobe(fallStrobe)
);

// File: tb/bitclk_gen_bench.sv
`timescale 1ns/1ps
module bitclk_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       psWrEn = 1'b0;
  logic [7:0] psWrData = '0;
  logic [7:0] psRdData;
  logic [7:0] rateIn = '0;
  logic       idlePol = 1'b0;
  logic       portEnable = 1'b0;
  logic       bitClk, riseStrobe, fallStrobe;

  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;

  typedef struct {
    bit    isRise;
    int    stamp;
    string tag;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  bitclk_gen u_bitclk_gen (
    .clk(clk), .rst_n(rst_n), .psWrEn(psWrEn), .psWrData(psWrData),
    .psRdData(psRdData), .rateIn(rateIn), .idlePol(idlePol),
    .portEnable(portEnable), .bitClk(bitClk), .riseStrobe(riseStrobe),
    .fallStrobe(fallStrobe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  // Monitor: pops predicted strobes and compares kind, stamp and level
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && (riseStrobe || fallStrobe)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R6 unexpected strobe", cyc, -1);
      end else begin
        e = q.pop_front();
        chk(!(riseStrobe && fallStrobe) && (riseStrobe == e.isRise),
            {e.tag, " R5 strobe kind"}, int'(riseStrobe), int'(e.isRise));
        chk(cyc == e.stamp, {e.tag, " strobe time"}, cyc, e.stamp);
        chk(bitClk == e.isRise, {e.tag, " R5 level at strobe"}, int'(bitClk), int'(e.isRise));
      end
    end
  end

  task automatic writePs(input int v);
    psWrData = 8'(v);
    psWrEn   = 1'b1;
    @(negedge clk);
    psWrEn   = 1'b0;
  endtask

  task automatic push(input bit isRise, input int stamp, input string tag);
    exp_t e;
    e.isRise = isRise;
    e.stamp  = stamp;
    e.tag    = tag;
    q.push_back(e);
  endtask

  // Driver: program, predict every toggle, run, then disable
  task automatic runPeriods(input int ps, input int rate, input bit pol,
                            input int nTog, input int extra, input string tag);
    int h, c0;
    writePs(ps);
    rateIn  = 8'(rate);
    idlePol = pol;
    @(negedge clk);
    @(negedge clk);
    h  = (ps / 2) * (rate + 1);
    c0 = cyc;
    for (int k = 1; k <= nTog; k++) push(((k % 2) == 1) != pol, c0 + k * h, tag);
    portEnable = 1'b1;
    repeat (nTog * h + extra) @(negedge clk);
    portEnable = 1'b0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, {tag, " all strobes seen"}, q.size(), 0);
    chk(bitClk == pol, {tag, " R6 idle level"}, int'(bitClk), int'(pol));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(psRdData == 8'd2, "R3 reset prescale", psRdData, 2);
    chk(bitClk == 1'b0 && !riseStrobe && !fallStrobe, "R6 reset idle", int'(bitClk), 0);

    // Read-back rules
    writePs(7);   chk(psRdData == 8'd6,   "R2 odd write", psRdData, 6);
    writePs(255); chk(psRdData == 8'd254, "R2 odd max write", psRdData, 254);
    writePs(1);   chk(psRdData == 8'd254, "R3 write of 1 ignored", psRdData, 254);
    writePs(0);   chk(psRdData == 8'd254, "R3 write of 0 ignored", psRdData, 254);
    writePs(10);  chk(psRdData == 8'd10,  "R2 even write", psRdData, 10);

    // Disabled: nothing moves
    repeat (20) @(negedge clk);
    chk(!riseStrobe && !fallStrobe && bitClk == 1'b0, "R6 disabled quiet", int'(bitClk), 0);

    // Divide ratios
    runPeriods(2, 0, 1'b0, 6, 0, "R1 min divide");
    runPeriods(6, 2, 1'b0, 4, 0, "R1 ps6 rate2");
    runPeriods(254, 0, 1'b0, 2, 0, "R1 max prescale");
    runPeriods(2, 255, 1'b0, 2, 0, "R4 rate 255");
    runPeriods(4, 3, 1'b1, 4, 0, "R8 idle high");
    // Mid-period disable, then fresh start
    runPeriods(8, 1, 1'b0, 1, 5, "R6 mid stop");
    runPeriods(8, 1, 1'b0, 2, 0, "R6 restart");

    // Prescale change mid-period: old half period until idle-return toggle
    writePs(4);
    rateIn  = 8'd1;
    idlePol = 1'b0;
    @(negedge clk); @(negedge clk);
    c0 = cyc;
    push(1'b1, c0 + 4,  "R7 ps old rise");
    push(1'b0, c0 + 8,  "R7 ps old fall");
    push(1'b1, c0 + 16, "R7 ps new rise");
    push(1'b0, c0 + 24, "R7 ps new fall");
    portEnable = 1'b1;
    repeat (4) @(negedge clk);
    writePs(8);
    repeat (19) @(negedge clk);
    portEnable = 1'b0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7 prescale change strobes", q.size(), 0);

    // Rate change mid-period
    writePs(2);
    rateIn = 8'd3;
    @(negedge clk); @(negedge clk);
    c0 = cyc;
    push(1'b1, c0 + 4,  "R7 rate old rise");
    push(1'b0, c0 + 8,  "R7 rate old fall");
    push(1'b1, c0 + 9,  "R7 rate new rise");
    push(1'b0, c0 + 10, "R7 rate new fall");
    portEnable = 1'b1;
    repeat (4) @(negedge clk);
    rateIn = 8'd0;
    repeat (6) @(negedge clk);
    portEnable = 1'b0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R7 rate change strobes", q.size(), 0);
    chk(bitClk == 1'b0, "R6 final idle", int'(bitClk), 0);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule